// File: doc/BRIEF.md
# Dual-Register Sticky Write Lock

This unit sits between a host write port and a register file. It guards four address groups against writes: working registers, power-sequence assignment registers, slot-timing registers and control registers. Two separate lock registers, at `LOCK_A_ADDR` (0xF0) and `LOCK_B_ADDR` (0xF1), hold one bit per group. A group is write-locked only when its bit is 1 in both lock registers.

Lock bits can only be set. A write to a lock register ORs the valid bits of the new data into the current value. Only the asynchronous power-on reset returns the bits to 0. Each host write is decoded by address and passed through one cycle later as a register-file strobe. A write that targets a locked group is dropped, and a one-cycle `wp_blocked` pulse is raised in its place. Reads of the register file do not pass through this unit, so locking has no effect on them. The lock registers themselves can be read back through a side read port.

Top module: `wp_unit`

## Requirements
- R1: After power-on reset, both lock registers read 0x00, and `reg_wr_en` and `wp_blocked` are 0.
- R2: A group is locked only when its bit is 1 in both lock registers. With the bit set in only one of them, writes to the group are forwarded.
- R3: A lock bit that is 1 stays 1 whatever data is later written to its register. A write ORs its data into the register.
- R4: Only bits 6, 4, 3 and 0 of a lock register can be set. Bits 7, 5, 2 and 1 always read 0.
- R5: A host write to a locked group gives `reg_wr_en`=0 and `wp_blocked`=1 in the following cycle. The pulse lasts one cycle per write.
- R6: A host write to an unlocked group or an unmapped address gives `reg_wr_en`=1 in the following cycle, with the same address and data, and `wp_blocked`=0.
- R7: The groups are: working 0x10–0x24 (lock bit 6), control 0x25–0x2B (bit 0), slot timing 0x30–0x32 (bit 3) and power sequence 0x33–0x3E (bit 4). Writes to any other address are never blocked.
- R8: Writes to 0xF0 or 0xF1 are never forwarded and never flagged as blocked. The new lock value applies to a host write issued in the very next cycle.
- R9: Locking one group has no effect on writes to the other groups.
- R10: `rd_data` returns the 0xF0 or 0xF1 lock register value when `rd_addr` selects it, and 0 for any other address, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| host_wr_en | input | 1 | Host write request strobe |
| host_addr | input | ADDR_W | Host write address |
| host_wdata | input | DATA_W | Host write data |
| rd_addr | input | ADDR_W | Lock register read address |
| rd_data | output | DATA_W | Lock register read data (combinational) |
| reg_wr_en | output | 1 | Gated write strobe to the register file |
| reg_wr_addr | output | ADDR_W | Forwarded write address |
| reg_wr_data | output | DATA_W | Forwarded write data |
| wp_blocked | output | 1 | One-cycle pulse for a dropped write |

## Verification
The bench first sets a group's bit in only one lock register and shows that writes still go through. A unit that used OR instead of AND for the lock would block them. It then writes zeros and all-ones to the lock registers. A plain-store register would lose its bits, and a register without a mask would show reserved bits set. It writes to the first and last address of every group and to the addresses just outside. An off-by-one range would block a neighbour or let an edge address through. Finally it issues a write on the cycle right after a lock write, which exposes a lock that takes effect one cycle late.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // number of protected address groups
    localparam int NUM_GRP = 4;

    // group order: 0 working, 1 power sequence, 2 slot timing, 3 control
    localparam int GRP_BIT [NUM_GRP] = '{6, 4, 3, 0};
    localparam int GRP_LO  [NUM_GRP] = '{32'h10, 32'h33, 32'h30, 32'h25};
    localparam int GRP_HI  [NUM_GRP] = '{32'h24, 32'h3E, 32'h32, 32'h2B};

    // mask of lock bits that belong to some group
    function automatic logic [31:0] grp_mask();
        logic [31:0] m;
        m = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            m[GRP_BIT[g]] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/wp_lock_regs.sv
module wp_lock_regs
    import wp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_a,
    input  logic                wr_b,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   lock_a_o,
    output logic [DATA_W-1:0]   lock_b_o,
    output logic [NUM_GRP-1:0]  lock_vec_o
);

    localparam logic [DATA_W-1:0] VALID_MASK = DATA_W'(grp_mask());

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_a) begin
            st_d.a = st_q.a | (wr_data & VALID_MASK);
        end
        if (wr_b) begin
            st_d.b = st_q.b | (wr_data & VALID_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_a_o = st_q.a;
    assign lock_b_o = st_q.b;

    // a group is locked only with agreement of both registers
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lock
        assign lock_vec_o[g] = st_q.a[GRP_BIT[g]] & st_q.b[GRP_BIT[g]];
    end

    // R3: bits never fall outside power-on reset
    p_set_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.a & $past(st_q.a)) == $past(st_q.a)) &&
        ((st_q.b & $past(st_q.b)) == $past(st_q.b)));

    // R4: reserved positions stay clear
    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.a | st_q.b) & ~VALID_MASK) == '0);

endmodule

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
    import wp_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] LOCK_A_ADDR = 8'hF0,
    parameter logic [ADDR_W-1:0] LOCK_B_ADDR = 8'hF1
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_GRP-1:0]  grp_hit_o,
    output logic                sel_a_o,
    output logic                sel_b_o
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_range
        assign grp_hit_o[g] = (int'(addr) >= GRP_LO[g]) && (int'(addr) <= GRP_HI[g]);
    end

    assign sel_a_o = (addr == LOCK_A_ADDR);
    assign sel_b_o = (addr == LOCK_B_ADDR);

endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    input  logic [NUM_GRP-1:0]  grp_hit,
    input  logic [NUM_GRP-1:0]  lock_vec,
    input  logic                lock_sel,
    output logic                fwd_wr_o,
    output logic [ADDR_W-1:0]   fwd_addr_o,
    output logic [DATA_W-1:0]   fwd_data_o,
    output logic                blocked_o
);

    typedef struct packed {
        logic              wr;
        logic              blk;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     hit_locked;

    always_comb begin
        hit_locked = |(grp_hit & lock_vec);
        st_d       = st_q;
        st_d.wr    = wr_en && !lock_sel && !hit_locked;
        st_d.blk   = wr_en && hit_locked;
        if (wr_en) begin
            st_d.addr = addr;
            st_d.data = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_wr_o   = st_q.wr;
    assign fwd_addr_o = st_q.addr;
    assign fwd_data_o = st_q.data;
    assign blocked_o  = st_q.blk;

endmodule

// File: rtl/wp_unit.sv
module wp_unit
    import wp_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] LOCK_A_ADDR = 8'hF0,
    parameter logic [ADDR_W-1:0] LOCK_B_ADDR = 8'hF1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              wp_blocked
);

    logic [NUM_GRP-1:0] grp_hit;
    logic [NUM_GRP-1:0] lock_vec;
    logic               sel_a, sel_b;
    logic [DATA_W-1:0]  lock_a, lock_b;

    wp_addr_decode #(
        .ADDR_W      (ADDR_W),
        .LOCK_A_ADDR (LOCK_A_ADDR),
        .LOCK_B_ADDR (LOCK_B_ADDR)
    ) u_decode (
        .addr      (host_addr),
        .grp_hit_o (grp_hit),
        .sel_a_o   (sel_a),
        .sel_b_o   (sel_b)
    );

    wp_lock_regs #(
        .DATA_W (DATA_W)
    ) u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_a       (host_wr_en && sel_a),
        .wr_b       (host_wr_en && sel_b),
        .wr_data    (host_wdata),
        .lock_a_o   (lock_a),
        .lock_b_o   (lock_b),
        .lock_vec_o (lock_vec)
    );

    wp_write_gate #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr_en),
        .addr       (host_addr),
        .data       (host_wdata),
        .grp_hit    (grp_hit),
        .lock_vec   (lock_vec),
        .lock_sel   (sel_a || sel_b),
        .fwd_wr_o   (reg_wr_en),
        .fwd_addr_o (reg_wr_addr),
        .fwd_data_o (reg_wr_data),
        .blocked_o  (wp_blocked)
    );

    always_comb begin
        if (rd_addr == LOCK_A_ADDR) begin
            rd_data = lock_a;
        end else if (rd_addr == LOCK_B_ADDR) begin
            rd_data = lock_b;
        end else begin
            rd_data = '0;
        end
    end

    // R5: a write into a locked group is dropped and flagged
    p_lock_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && ((grp_hit & lock_vec) != '0)) |=> (wp_blocked && !reg_wr_en));

    // R6: a write into an open group or unmapped address goes through
    p_free_passes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && ((grp_hit & lock_vec) == '0) && !sel_a && !sel_b)
            |=> (reg_wr_en && !wp_blocked && reg_wr_addr == $past(host_addr)));

    // R8: lock register writes stay inside this unit
    p_lock_write_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && (sel_a || sel_b)) |=> (!reg_wr_en && !wp_blocked));

    // R5: blocked pulse and forwarded strobe never coincide
    p_excl_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wp_blocked && reg_wr_en));

endmodule

// File: tb/wp_unit_bench.sv
`timescale 1ns/1ps
module wp_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       reg_wr_en;
    logic [7:0] reg_wr_addr;
    logic [7:0] reg_wr_data;
    logic       wp_blocked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       wr;
        logic       blk;
        logic [7:0] addr;
        logic [7:0] data;
        int         req;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] ma = '0;
    logic [7:0] mb = '0;

    always #2.5 clk = ~clk;

    wp_unit u_wp_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr_en  (host_wr_en),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .wp_blocked  (wp_blocked)
    );

    // lock bit owning an address, or -1 for unmapped (R7)
    function automatic int bit_of(logic [7:0] a);
        if (a >= 8'h25 && a <= 8'h2B) return 0;
        if (a >= 8'h30 && a <= 8'h32) return 3;
        if (a >= 8'h33 && a <= 8'h3E) return 4;
        if (a >= 8'h10 && a <= 8'h24) return 6;
        return -1;
    endfunction

    task automatic chk(bit ok, int req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: one host write, expectation pushed into scoreboard
    task automatic wr(logic [7:0] a, logic [7:0] d, int req);
        item_t it;
        int    b;
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr  = a;
        host_wdata = d;
        b = bit_of(a);
        it.addr = a;
        it.data = d;
        it.req  = req;
        if (a == 8'hF0 || a == 8'hF1) begin
            it.wr  = 1'b0;
            it.blk = 1'b0;
            if (a == 8'hF0) ma = ma | (d & 8'h59);
            else            mb = mb | (d & 8'h59);
        end else if (b >= 0 && ma[b] && mb[b]) begin
            it.wr  = 1'b0;
            it.blk = 1'b1;
        end else begin
            it.wr  = 1'b1;
            it.blk = 1'b0;
        end
        exp_q.push_back(it);
    endtask

    // idle cycle with a lock register read (R10)
    task automatic rd(logic [7:0] a, logic [7:0] exp, int req);
        item_t it;
        @(negedge clk);
        host_wr_en = 1'b0;
        rd_addr    = a;
        it.wr = 1'b0; it.blk = 1'b0; it.addr = '0; it.data = '0; it.req = req;
        exp_q.push_back(it);
        #1;
        chk(rd_data == exp, req, "rd_data", {8'h0, rd_data}, {8'h0, exp});
    endtask

    // monitor: compare outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                chk(reg_wr_en == e.wr, e.req, "reg_wr_en", {15'h0, reg_wr_en}, {15'h0, e.wr});
                chk(wp_blocked == e.blk, e.req, "wp_blocked", {15'h0, wp_blocked}, {15'h0, e.blk});
                if (e.wr) begin
                    chk({reg_wr_addr, reg_wr_data} == {e.addr, e.data}, e.req, "addr/data",
                        {reg_wr_addr, reg_wr_data}, {e.addr, e.data});
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(reg_wr_en == 1'b0 && wp_blocked == 1'b0, 1, "outputs in reset",
            {15'h0, reg_wr_en | wp_blocked}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'hF0, 8'h00, 1); // R1
        rd(8'hF1, 8'h00, 1); // R1
        rd(8'h25, 8'h00, 10); // R10 non-lock address reads 0

        wr(8'h26, 8'h11, 6);  // R6 open group
        wr(8'h50, 8'hA5, 6);  // R6 unmapped
        wr(8'hF0, 8'h01, 8);  // R8 control bit in A only
        wr(8'h28, 8'h22, 2);  // R2 one register alone: passes
        wr(8'hF1, 8'h01, 8);  // R8 control now locked
        wr(8'h2B, 8'h33, 5);  // R5 locked, issued right after lock write (R8)
        wr(8'h25, 8'h44, 7);  // R7 lower edge of control
        wr(8'h24, 8'h55, 9);  // R9 working group unaffected
        wr(8'h2C, 8'h66, 7);  // R7 just above control
        wr(8'hF0, 8'h00, 3);  // R3 writing zeros
        wr(8'hF1, 8'h00, 3);  // R3
        rd(8'hF0, 8'h01, 3);  // R3
        rd(8'hF1, 8'h01, 3);  // R3
        wr(8'h27, 8'h77, 3);  // R3 still locked
        wr(8'hF0, 8'hFF, 4);  // R4 all ones
        rd(8'hF0, 8'h59, 4);  // R4 reserved bits clear
        wr(8'h30, 8'h88, 2);  // R2 slot bit only in A
        wr(8'hF1, 8'h08, 8);  // R8 lock slot timing
        wr(8'h30, 8'h99, 7);  // R7 slot low edge
        wr(8'h32, 8'h9A, 7);  // R7 slot high edge
        wr(8'h33, 8'h9B, 9);  // R9 power sequence still open
        wr(8'h2F, 8'h9C, 7);  // R7 gap address
        wr(8'hF1, 8'hFF, 4);  // R4 all groups
        rd(8'hF1, 8'h59, 4);  // R4
        wr(8'h33, 8'hAA, 7);  // R7 power sequence low edge
        wr(8'h3E, 8'hAB, 7);  // R7 power sequence high edge
        wr(8'h10, 8'hAC, 7);  // R7 working low edge
        wr(8'h24, 8'hAD, 5);  // R5 working high edge
        wr(8'h3F, 8'hAE, 7);  // R7 above power sequence
        wr(8'h0F, 8'hAF, 7);  // R7 below working
        wr(8'hF0, 8'h00, 8);  // R8 lock writes never forwarded
        rd(8'h00, 8'h00, 5);  // R5 blocked pulse ends after one cycle

        @(negedge clk);
        host_wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(exp_q.size() == 0, 6, "scoreboard drained", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule